// File: doc/BRIEF.md
# Wait-State Host Bus Interface

This block arbitrates host CPU cycles into a shared word store made of a RAM and a small register file. An internal engine also works on the RAM. The host opens a cycle by pulling its chip-select and strobe low, and it may do so with no regard to the block clock. The block passes that request through a synchronizer. When the engine is not using the RAM, it grants the cycle by pulling an active-low enable output low. After a fixed number of wait clocks it signals completion on an active-low ready output.

The access kind and direction are captured on the first falling clock edge after the grant. The address is captured on the first rising edge after the grant. Before those edges the inputs are followed live. After them, changes on the inputs have no effect. A read/write polarity input selects which level of the direction line means read. Select and strobe may be tied together. The host may release the strobe at any time after the grant without cancelling the cycle. If it keeps the strobe low, ready stays low until the strobe goes back high.

Top module: `hbus_wait_if`

## Requirements
- R1: While reset is asserted and after its release with no request, ioen_no and ready_no are 1, rdata_oe_o is 0 and rdata_o is zero.
- R2: A request exists only while sel_ni and strb_ni are both 0. With the engine idle, if the request is present before rising edge E, ioen_no falls at edge E+2. With only one of the two lines low, ioen_no stays 1.
- R3: ioen_no never falls at a rising edge where eng_busy_i is 1. A request held during engine activity is granted at the first rising edge that finds eng_busy_i at 0 and the request synchronized.
- R4: A request that first appears just after edge E, rather than just before it, is granted exactly one clock later, at edge E+3.
- R5: memreg_i at 1 selects the RAM, addressed by addr_i[7:0]. memreg_i at 0 selects the register file, addressed by addr_i[2:0]. All words are zero after reset.
- R6: memreg_i and the direction decode follow their inputs until the first falling edge after ioen_no falls. Changes after that edge have no effect on the cycle.
- R7: addr_i follows its input until the first rising edge after ioen_no falls. It is captured at that edge, and later changes have no effect.
- R8: With rd_pol_i at 1, rdwr_i at 1 means read. With rd_pol_i at 0, rdwr_i at 0 means read. The opposite level means write.
- R9: ready_no falls WAIT_CYC (default 2) rising edges after the address capture edge. A write stores wdata_i at that edge. For a read, rdata_o carries the selected word while ready_no is low.
- R10: If the request is still present, ready_no stays low until the request is removed. Then ioen_no and ready_no both return to 1 at the third rising edge after the removal.
- R11: Removing the request after ioen_no has fallen does not abort the cycle. ready_no still falls, and the block then returns to idle.
- R12: rdata_oe_o is 1 only while ioen_no is 0 and the cycle is a read. rdata_o is zero whenever ioen_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Host chip select, active low, asynchronous |
| strb_ni | input | 1 | Host strobe, active low, asynchronous |
| memreg_i | input | 1 | 1 = RAM, 0 = register file |
| rdwr_i | input | 1 | Direction; sense set by rd_pol_i |
| rd_pol_i | input | 1 | Direction polarity: 1 = high reads, 0 = low reads |
| addr_i | input | 16 | Host address |
| wdata_i | input | 16 | Host write data |
| eng_busy_i | input | 1 | Internal engine is using the RAM |
| ioen_no | output | 1 | Cycle granted, active low |
| ready_no | output | 1 | Access complete, active low |
| rdata_oe_o | output | 1 | Read data is driven |
| rdata_o | output | 16 | Read data, zero when not driven |

## Verification
A stuck or skipped arbitration state shows up as a grant that arrives at the wrong edge, either relative to the request or relative to engine activity. It can also show up as a ready pulse that comes too early or never ends. Either is visible within a few clocks of the request. Capture registers that open at the wrong edge, or never close, make a read return a word from the wrong address or the wrong store. A bad polarity decode turns a read into a write, and the damage shows on the next read-back of that word. The bench times every grant against a reference edge, and it changes the control and address inputs on either side of the capture edges.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } hbus_state_e;

  typedef struct packed {
    logic mem;
    logic rd;
  } hbus_ctrl_t;
endpackage

// File: rtl/hbus_req_sync.sv
module hbus_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[0] <= 1'b0;
          else         q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[g] <= 1'b0;
          else         q[g] <= q[g-1];
      end
    end
  endgenerate

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/hbus_cyc_fsm.sv
module hbus_cyc_fsm
  import hbus_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        busy_i,
  output hbus_state_e state_o,
  output logic        acc_o
);
  localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  hbus_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_o   = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_i && !busy_i) state_d = ST_GRANT;
      ST_GRANT: begin
        state_d = ST_WAIT;
        cnt_d   = '0;
      end
      ST_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_DONE;
          acc_o   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE:  if (!req_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end

  assign state_o = state_q;
endmodule

// File: rtl/hbus_latch.sv
module hbus_latch
  import hbus_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          addr_le_i,
  input  hbus_ctrl_t    ctrl_i,
  input  logic [AW-1:0] addr_i,
  output hbus_ctrl_t    ctrl_o,
  output logic [AW-1:0] addr_o
);
  hbus_ctrl_t    ctrl_q;
  logic          ctrl_vld_q;
  logic [AW-1:0] addr_q;
  logic          addr_vld_q;

  // control closes on the first falling edge of a granted cycle
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctrl_q     <= '0;
      ctrl_vld_q <= 1'b0;
    end else if (!active_i) begin
      ctrl_vld_q <= 1'b0;
    end else if (!ctrl_vld_q) begin
      ctrl_q     <= ctrl_i;
      ctrl_vld_q <= 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q     <= '0;
      addr_vld_q <= 1'b0;
    end else if (addr_le_i) begin
      addr_q     <= addr_i;
      addr_vld_q <= 1'b1;
    end else if (!active_i) begin
      addr_vld_q <= 1'b0;
    end

  assign ctrl_o = ctrl_vld_q ? ctrl_q : ctrl_i;
  assign addr_o = addr_vld_q ? addr_q : addr_i;
endmodule

// File: rtl/hbus_store.sv
module hbus_store #(
  parameter int unsigned DW     = 16,
  parameter int unsigned RAM_AW = 8,
  parameter int unsigned REG_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic              mem_i,
  input  logic [RAM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int unsigned RAM_DEPTH = 1 << RAM_AW;
  localparam int unsigned REG_NUM   = 1 << REG_AW;

  logic [DW-1:0]     ram_q [RAM_DEPTH];
  logic [DW-1:0]     reg_q [REG_NUM];
  logic [DW-1:0]     rd_q;
  logic [REG_AW-1:0] reg_idx;

  assign reg_idx = addr_i[REG_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
    end else if (acc_i && wr_i && mem_i) begin
      ram_q[addr_i] <= wdata_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < REG_NUM; i++) reg_q[i] <= '0;
    end else if (acc_i && wr_i && !mem_i) begin
      reg_q[reg_idx] <= wdata_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               rd_q <= '0;
    else if (acc_i && !wr_i)   rd_q <= mem_i ? ram_q[addr_i] : reg_q[reg_idx];

  assign rdata_o = rd_q;
endmodule

// File: rtl/hbus_wait_if.sv
module hbus_wait_if
  import hbus_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 16,
  parameter int unsigned RAM_AW      = 8,
  parameter int unsigned REG_AW      = 3,
  parameter int unsigned WAIT_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_ni,
  input  logic          strb_ni,
  input  logic          memreg_i,
  input  logic          rdwr_i,
  input  logic          rd_pol_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eng_busy_i,
  output logic          ioen_no,
  output logic          ready_no,
  output logic          rdata_oe_o,
  output logic [DW-1:0] rdata_o
);
  hbus_state_e       state;
  hbus_ctrl_t        ctrl_live, ctrl_eff;
  logic [RAM_AW-1:0] addr_eff;
  logic [DW-1:0]     rd_word;
  logic              req_sync, acc, active, granted;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^addr_i[AW-1:RAM_AW];

  assign ctrl_live.mem = memreg_i;
  assign ctrl_live.rd  = rd_pol_i ? rdwr_i : ~rdwr_i;

  hbus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (~sel_ni & ~strb_ni),
    .sync_o  (req_sync)
  );

  hbus_cyc_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_sync),
    .busy_i  (eng_busy_i),
    .state_o (state),
    .acc_o   (acc)
  );

  assign active  = (state != ST_IDLE);
  assign granted = active;

  hbus_latch #(.AW(RAM_AW)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .addr_le_i (state == ST_GRANT),
    .ctrl_i    (ctrl_live),
    .addr_i    (addr_i[RAM_AW-1:0]),
    .ctrl_o    (ctrl_eff),
    .addr_o    (addr_eff)
  );

  hbus_store #(.DW(DW), .RAM_AW(RAM_AW), .REG_AW(REG_AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .wr_i    (~ctrl_eff.rd),
    .mem_i   (ctrl_eff.mem),
    .addr_i  (addr_eff),
    .wdata_i (wdata_i),
    .rdata_o (rd_word)
  );

  assign ioen_no    = ~granted;
  assign ready_no   = (state != ST_DONE);
  assign rdata_oe_o = granted & ctrl_eff.rd;
  assign rdata_o    = rdata_oe_o ? rd_word : '0;
endmodule

// File: rtl/hbus_wait_if_chk.sv
module hbus_wait_if_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          eng_busy_i,
  input logic          ioen_no,
  input logic          ready_no,
  input logic          rdata_oe_o,
  input logic [DW-1:0] rdata_o
);
  assert_busy_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ioen_no && eng_busy_i) |=> ioen_no);

  assert_no_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ioen_no && ready_no) |=> !ioen_no);

  assert_end_after_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ioen_no) |-> $past(!ready_no));

  assert_oe_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ioen_no && $past(!ioen_no)) |-> $stable(rdata_oe_o));

  assert_wait_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ioen_no) |=> ready_no);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ioen_no |-> (rdata_o == '0));
endmodule

bind hbus_wait_if hbus_wait_if_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eng_busy_i (eng_busy_i),
  .ioen_no    (ioen_no),
  .ready_no   (ready_no),
  .rdata_oe_o (rdata_oe_o),
  .rdata_o    (rdata_o)
);

// File: tb/hbus_wait_if_tb.sv
`timescale 1ns/1ps
module hbus_wait_if_tb;
  localparam int WAIT_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, strb_n = 1'b1, memreg = 1'b0, rdwr = 1'b1, rd_pol = 1'b1;
  logic [15:0] addr = '0, wdata = '0;
  logic        eng_busy = 1'b0;
  logic        ioen_no, ready_no, rdata_oe;
  logic [15:0] rdata;

  int n_cmp = 0, n_err = 0;
  logic [15:0] mem_m [256];
  logic [15:0] reg_m [8];

  always #4 clk = ~clk;

  hbus_wait_if #(.WAIT_CYC(WAIT_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .strb_ni(strb_n),
    .memreg_i(memreg), .rdwr_i(rdwr), .rd_pol_i(rd_pol), .addr_i(addr),
    .wdata_i(wdata), .eng_busy_i(eng_busy), .ioen_no(ioen_no),
    .ready_no(ready_no), .rdata_oe_o(rdata_oe), .rdata_o(rdata));

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input bit mem, input logic [15:0] a);
    return mem ? mem_m[a[7:0]] : reg_m[a[2:0]];
  endfunction

  function automatic int exp_grant(input int busy_k);
    return (busy_k + 1 > 3) ? busy_k + 1 : 3;
  endfunction

  task automatic drive_ctrl(input bit mem, input bit rd, input logic [15:0] a,
                            input logic [15:0] wd, input bit pol);
    memreg = mem; rd_pol = pol; rdwr = pol ? rd : !rd; addr = a; wdata = wd;
  endtask

  // waits from P0+2 until grant is seen; returns ticks taken
  task automatic wait_grant(input int busy_k, output int n);
    n = 0;
    do begin
      tick(); n++;
      if (n == busy_k) eng_busy = 1'b0;
    end while (ioen_no && n < 20);
  endtask

  // entered at P3+2 with the grant just seen
  task automatic finish_cycle(input bit mem, input bit rd, input logic [15:0] a,
                              input logic [15:0] wd, input bit early,
                              input bit tamper_late, input int hold);
    int n;
    tick();
    if (early) strb_n = 1'b1;
    if (tamper_late) begin
      memreg = !memreg; rdwr = !rdwr; addr = addr ^ 16'h5a5a;
    end
    for (int k = 1; k < WAIT_CYC; k++) begin
      tick(); chk(ready_no === 1'b1, "R9", "ready too early", ready_no, 1);
    end
    tick();
    chk(ready_no === 1'b0, "R9", "ready after wait", ready_no, 0);
    if (rd) begin
      chk(rdata_oe === 1'b1, "R12", "oe on read", rdata_oe, 1);
      chk(rdata === model_rd(mem, a), tamper_late ? "R6/R7 R5" : "R5", "read word",
          rdata, model_rd(mem, a));
    end else begin
      chk(rdata_oe === 1'b0, "R12", "oe on write", rdata_oe, 0);
      if (mem) mem_m[a[7:0]] = wd; else reg_m[a[2:0]] = wd;
    end
    if (!early) begin
      for (int k = 0; k < hold; k++) begin
        tick(); chk(ready_no === 1'b0, "R10", "ready held", ready_no, 0);
      end
      sel_n = 1'b1; strb_n = 1'b1;
      tick(); chk(ready_no === 1'b0, "R10", "ready after release", ready_no, 0);
      n = 0;
      do begin tick(); n++; end while (ioen_no === 1'b0 && n < 8);
      chk(n == 2, "R10", "release to idle", n, 2);
      chk(ready_no === 1'b1, "R10", "ready idle", ready_no, 1);
    end else begin
      n = 0;
      do begin tick(); n++; end while (ioen_no === 1'b0 && n < 8);
      chk(ioen_no === 1'b1 && ready_no === 1'b1, "R11", "idle after early release",
          {ioen_no, ready_no}, 2'b11);
      sel_n = 1'b1;
    end
    tick();
    chk(rdata_oe === 1'b0 && rdata === 16'h0, "R12", "idle bus", rdata, 0);
  endtask

  task automatic access(input bit mem, input bit rd, input logic [15:0] a,
                        input logic [15:0] wd, input bit pol, input int busy_k,
                        input int tamper, input bit early, input int hold,
                        input bit tie);
    int n;
    bit m2;
    logic [15:0] a2;
    drive_ctrl(mem, rd, a, wd, pol);
    eng_busy = (busy_k != 0);
    sel_n = 1'b0; strb_n = 1'b0;
    if (tie) sel_n = strb_n;
    wait_grant(busy_k, n);
    chk(n == exp_grant(busy_k), busy_k > 2 ? "R3" : "R2", "grant edge", n, exp_grant(busy_k));
    m2 = mem; a2 = a;
    if (tamper == 2) begin
      // before both capture edges: new values must be used
      m2 = !mem; a2 = a ^ 16'h0033;
      memreg = m2; addr = a2;
    end
    finish_cycle(m2, rd, a2, wd, early, tamper == 1, hold);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    for (int i = 0; i < 8; i++) reg_m[i] = '0;
    void'($urandom(32'h00c0ffee));

    #10;
    chk(ioen_no === 1'b1 && ready_no === 1'b1, "R1", "in reset", {ioen_no, ready_no}, 2'b11);
    chk(rdata_oe === 1'b0 && rdata === 16'h0, "R1", "bus in reset", rdata, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (3) tick();
    chk(ioen_no === 1'b1 && ready_no === 1'b1, "R1", "after reset", {ioen_no, ready_no}, 2'b11);

    // R2: only one line low gives no cycle
    sel_n = 1'b0;
    repeat (6) begin tick(); chk(ioen_no === 1'b1, "R2", "select alone", ioen_no, 1); end
    sel_n = 1'b1; strb_n = 1'b0;
    repeat (6) begin tick(); chk(ioen_no === 1'b1, "R2", "strobe alone", ioen_no, 1); end
    strb_n = 1'b1;
    repeat (4) tick();

    // R5/R8: directed writes then reads, both polarities, tied select/strobe
    access(1'b0, 1'b0, 16'hff03, 16'hbeef, 1'b1, 0, 0, 1'b0, 1, 1'b0);
    access(1'b1, 1'b0, 16'h0103, 16'h1234, 1'b0, 0, 0, 1'b0, 0, 1'b1);
    access(1'b0, 1'b1, 16'h000b, 16'h0, 1'b0, 0, 0, 1'b0, 0, 1'b0);
    access(1'b1, 1'b1, 16'hab03, 16'h0, 1'b1, 0, 0, 1'b0, 2, 1'b1);
    chk(1'b1, "R8", "polarity pair done", 0, 0);

    // R3: long engine activity
    access(1'b1, 1'b1, 16'h0003, 16'h0, 1'b1, 7, 0, 1'b0, 0, 1'b0);

    // R6/R7: late change ignored, early change used
    access(1'b0, 1'b1, 16'h0003, 16'h0, 1'b1, 0, 1, 1'b0, 0, 1'b0);
    access(1'b1, 1'b0, 16'h0030, 16'h7777, 1'b1, 0, 2, 1'b0, 0, 1'b0);
    access(1'b0, 1'b1, 16'h0030, 16'h0, 1'b1, 0, 2, 1'b0, 0, 1'b0);

    // R11: early strobe release
    access(1'b1, 1'b1, 16'h0003, 16'h0, 1'b0, 0, 0, 1'b1, 0, 1'b0);

    // R4: request just before vs just after a reference edge
    drive_ctrl(1'b1, 1'b1, 16'h0003, 16'h0, 1'b1);
    #5; sel_n = 1'b0; strb_n = 1'b0;   // 1 ns before edge E
    tick(); n = 0;
    do begin tick(); n++; end while (ioen_no && n < 20);
    chk(n == 2, "R4", "setup met", n, 2);
    finish_cycle(1'b1, 1'b1, 16'h0003, 16'h0, 1'b0, 1'b0, 0);
    @(posedge clk); #1; sel_n = 1'b0; strb_n = 1'b0;   // 1 ns after edge E
    #1; n = 0;
    do begin tick(); n++; end while (ioen_no && n < 20);
    chk(n == 3, "R4", "setup missed", n, 3);
    finish_cycle(1'b1, 1'b1, 16'h0003, 16'h0, 1'b0, 1'b0, 0);

    // random mix
    for (int it = 0; it < 120; it++) begin
      bit mem, rd, pol, early, tie;
      int busy_k, tamper, hold;
      logic [15:0] a, wd;
      mem = 1'($urandom); rd = 1'($urandom); pol = 1'($urandom);
      a = 16'($urandom); wd = 16'($urandom);
      busy_k = int'($urandom % 6); tamper = int'($urandom % 3);
      early = ($urandom % 6) == 0; hold = int'($urandom % 4); tie = 1'($urandom);
      access(mem, rd, a, wd, pol, busy_k, tamper, early, hold, tie);
      repeat (int'($urandom % 3)) tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule